// File: doc/BRIEF.md
# Matrix-Multiply Micro-Op Sequencer

This block turns one half-precision matrix-multiply-accumulate request into a fixed run of 32 micro-operations for a tensor execution unit. A front end offers the request on a start handshake. The sequencer then walks an internal sequence number from 0 to 31. It splits each count into a set, a step and a substep, and from these it forms the register indices, the operation code and the modifier of the micro-op that it presents on an output handshake.

The controller has two states. In `ST_IDLE` the start input is ready and no micro-op is offered. A start request moves it to `ST_ISSUE` (transition *accept*). In `ST_ISSUE` a micro-op is offered every cycle. Each accepted micro-op advances the sequence number (transition *advance*, which stays in `ST_ISSUE`). Acceptance of the micro-op at sequence 31 returns the controller to `ST_IDLE` with the counter at 0 (transition *finish*). That micro-op carries a finish tag, so the front end knows when it can resume normal fetch. Its destination equals its third source, so every micro-op accumulates in place.

Top module: `mma_uop_seq`

## Requirements
- R1: A synchronous active-high `rst` puts the block in `ST_IDLE` with the sequence number at 0. In that state `start_ready` is 1 and `uop_valid` is 0.
- R2: A start request is accepted only in `ST_IDLE`. While micro-ops are being issued, `start_ready` is 0 and `start_valid` has no effect on the micro-op stream. The cycle after a start is accepted, `uop_valid` is 1 and the first micro-op has sequence 0.
- R3: The 32 micro-ops are issued in sequence order 0 to 31. The sequence advances only in a cycle where `uop_valid` and `uop_ready` are both 1. While `uop_ready` is 0, the offered micro-op stays unchanged.
- R4: For sequence number n, `uop_opcode` equals the step, (n mod 8) / 2, and `uop_modifier` equals the substep, n mod 2.
- R5: `uop_rs1` equals 2*set + substep, where set = n / 8. Its range is 0 to 7.
- R6: `uop_rs2` equals 8 + 2*set + substep. Its range is 8 to 15.
- R7: `uop_rs3` and `uop_rd` both equal 16 + 2*step + substep. Their range is 16 to 23.
- R8: `uop_last` is 1 only at sequence 31. `uop_next_seq` equals (n + 1) mod 32, so it is 0 at sequence 31.
- R9: `uop_imm_a` and `uop_imm_b` are both 1 when `uop_last` is 1 and 0 otherwise. `uop_flags` is always 3'b100, and `uop_exec_unit` is always 3'd4, which selects the tensor unit.
- R10: The cycle after the sequence-31 micro-op is accepted, `uop_valid` is 0 and `start_ready` is 1. The next run starts again at sequence 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Expansion request offered |
| start_ready | output | 1 | Request can be taken (idle) |
| uop_valid | output | 1 | Micro-op offered |
| uop_ready | input | 1 | Execution unit takes the micro-op |
| uop_exec_unit | output | 3 | Execute-unit select (tensor = 4) |
| uop_opcode | output | 4 | Operation code, carries the step |
| uop_modifier | output | 3 | Modifier, carries the substep |
| uop_flags | output | 3 | Fixed flag pattern 3'b100 |
| uop_imm_a | output | 32 | First immediate/PC field, 1 on finish |
| uop_imm_b | output | 32 | Second immediate/PC field, 1 on finish |
| uop_rs1 | output | 5 | First source register index |
| uop_rs2 | output | 5 | Second source register index |
| uop_rs3 | output | 5 | Third source register index |
| uop_rd | output | 5 | Destination register index |
| uop_last | output | 1 | Finish tag (1) versus continue (0) |
| uop_next_seq | output | 5 | Sequence number of the following micro-op |

## Verification
The hardest situation to bring about is the finish transition combined with back-pressure and competing starts. In that case the sequence-31 micro-op is stalled for several cycles while `start_valid` stays high. The block must then drop into idle for exactly one cycle and restart cleanly at sequence 0. The stimulus holds `start_valid` high continuously and gives `uop_ready` a low acceptance rate. This makes runs reach sequence 31 under stall and then follow each other back to back. A reset pulse in the middle of a run checks that no partial sequence survives.

// File: rtl/mma_uop_pkg.sv
package mma_uop_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } seq_state_e;

    localparam logic [2:0] EXU_TENSOR = 3'd4;
    localparam logic [2:0] UOP_FLAGS  = 3'b100;

endpackage

// File: rtl/mma_uop_decode.sv
module mma_uop_decode #(
    parameter int NUM_SETS     = 4,
    parameter int NUM_STEPS    = 4,
    parameter int NUM_SUBSTEPS = 2,
    parameter int REG_W        = 5,
    parameter int OP_W         = 4,
    parameter int MOD_W        = 3,
    parameter int SEQ_W        = 5
) (
    input  logic [SEQ_W-1:0] seq_i,
    output logic [OP_W-1:0]  opcode_o,
    output logic [MOD_W-1:0] modifier_o,
    output logic [REG_W-1:0] rs1_o,
    output logic [REG_W-1:0] rs2_o,
    output logic [REG_W-1:0] rs3_o,
    output logic [REG_W-1:0] rd_o,
    output logic             last_o,
    output logic [SEQ_W-1:0] next_seq_o
);

    localparam int PER_SET  = NUM_STEPS * NUM_SUBSTEPS;
    localparam int TOTAL    = NUM_SETS * PER_SET;
    localparam int BANK_SZ  = NUM_SETS * NUM_SUBSTEPS;
    localparam int RS2_BASE = BANK_SZ;
    localparam int ACC_BASE = 2 * BANK_SZ;

    int seq_v;
    int set_v;
    int step_v;
    int sub_v;
    int acc_v;

    always_comb begin
        seq_v  = int'(seq_i);
        set_v  = seq_v / PER_SET;
        step_v = (seq_v % PER_SET) / NUM_SUBSTEPS;
        sub_v  = seq_v % NUM_SUBSTEPS;
        acc_v  = ACC_BASE + NUM_SUBSTEPS * step_v + sub_v;

        opcode_o   = OP_W'(step_v);
        modifier_o = MOD_W'(sub_v);
        rs1_o      = REG_W'(NUM_SUBSTEPS * set_v + sub_v);
        rs2_o      = REG_W'(RS2_BASE + NUM_SUBSTEPS * set_v + sub_v);
        rs3_o      = REG_W'(acc_v);
        rd_o       = REG_W'(acc_v);
        last_o     = (seq_v == TOTAL - 1);
        next_seq_o = last_o ? '0 : SEQ_W'(seq_v + 1);
    end

endmodule

// File: rtl/mma_uop_ctrl.sv
module mma_uop_ctrl
    import mma_uop_pkg::*;
#(
    parameter int SEQ_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_valid,
    output logic             start_ready,
    output logic             uop_valid,
    input  logic             uop_ready,
    input  logic             at_last,
    output logic [SEQ_W-1:0] seq_o
);

    seq_state_e       state_q, state_d;
    logic [SEQ_W-1:0] seq_q, seq_d;

    // state and counter register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            seq_q   <= '0;
        end else begin
            state_q <= state_d;
            seq_q   <= seq_d;
        end
    end

    // transitions: accept, advance, finish
    always_comb begin
        state_d = state_q;
        seq_d   = seq_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_valid) state_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (uop_ready) begin
                    if (at_last) begin
                        state_d = ST_IDLE;
                        seq_d   = '0;
                    end else begin
                        seq_d = seq_q + 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        start_ready = 1'b0;
        uop_valid   = 1'b0;
        unique case (state_q)
            ST_IDLE:  start_ready = 1'b1;
            ST_ISSUE: uop_valid   = 1'b1;
            default:  start_ready = 1'b0;
        endcase
    end

    assign seq_o = seq_q;

endmodule

// File: rtl/mma_uop_seq.sv
module mma_uop_seq
    import mma_uop_pkg::*;
#(
    parameter int NUM_SETS     = 4,
    parameter int NUM_STEPS    = 4,
    parameter int NUM_SUBSTEPS = 2,
    parameter int REG_W        = 5,
    parameter int OP_W         = 4,
    parameter int MOD_W        = 3,
    parameter int IMM_W        = 32,
    localparam int TOTAL       = NUM_SETS * NUM_STEPS * NUM_SUBSTEPS,
    localparam int SEQ_W       = $clog2(TOTAL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_valid,
    output logic             start_ready,
    output logic             uop_valid,
    input  logic             uop_ready,
    output logic [2:0]       uop_exec_unit,
    output logic [OP_W-1:0]  uop_opcode,
    output logic [MOD_W-1:0] uop_modifier,
    output logic [2:0]       uop_flags,
    output logic [IMM_W-1:0] uop_imm_a,
    output logic [IMM_W-1:0] uop_imm_b,
    output logic [REG_W-1:0] uop_rs1,
    output logic [REG_W-1:0] uop_rs2,
    output logic [REG_W-1:0] uop_rs3,
    output logic [REG_W-1:0] uop_rd,
    output logic             uop_last,
    output logic [SEQ_W-1:0] uop_next_seq
);

    logic [SEQ_W-1:0] seq;

    mma_uop_ctrl #(.SEQ_W(SEQ_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_valid (start_valid),
        .start_ready (start_ready),
        .uop_valid   (uop_valid),
        .uop_ready   (uop_ready),
        .at_last     (uop_last),
        .seq_o       (seq)
    );

    mma_uop_decode #(
        .NUM_SETS     (NUM_SETS),
        .NUM_STEPS    (NUM_STEPS),
        .NUM_SUBSTEPS (NUM_SUBSTEPS),
        .REG_W        (REG_W),
        .OP_W         (OP_W),
        .MOD_W        (MOD_W),
        .SEQ_W        (SEQ_W)
    ) u_decode (
        .seq_i      (seq),
        .opcode_o   (uop_opcode),
        .modifier_o (uop_modifier),
        .rs1_o      (uop_rs1),
        .rs2_o      (uop_rs2),
        .rs3_o      (uop_rs3),
        .rd_o       (uop_rd),
        .last_o     (uop_last),
        .next_seq_o (uop_next_seq)
    );

    assign uop_exec_unit = EXU_TENSOR;
    assign uop_flags     = UOP_FLAGS;
    assign uop_imm_a     = {{(IMM_W-1){1'b0}}, uop_last};
    assign uop_imm_b     = {{(IMM_W-1){1'b0}}, uop_last};

endmodule

// File: rtl/mma_uop_seq_chk.sv
module mma_uop_seq_chk #(
    parameter int REG_W   = 5,
    parameter int IMM_W   = 32,
    parameter int SEQ_W   = 5,
    parameter int RS2_GAP = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start_valid,
    input logic             start_ready,
    input logic             uop_valid,
    input logic             uop_ready,
    input logic [IMM_W-1:0] uop_imm_a,
    input logic [REG_W-1:0] uop_rs1,
    input logic [REG_W-1:0] uop_rs2,
    input logic [REG_W-1:0] uop_rd,
    input logic             uop_last,
    input logic [SEQ_W-1:0] uop_next_seq
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        start_ready |-> !uop_valid);  // R1

    AST_START_TO_ISSUE: assert property (@(posedge clk) disable iff (rst)
        start_valid && start_ready |=> uop_valid && !start_ready);  // R2

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        uop_valid && !uop_ready |=> uop_valid && $stable(uop_next_seq)
            && $stable(uop_rs1) && $stable(uop_rd));  // R3

    AST_RS2_GAP: assert property (@(posedge clk) disable iff (rst)
        uop_valid |-> uop_rs2 == REG_W'(uop_rs1 + RS2_GAP));  // R6

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        uop_valid && uop_ready && !uop_last |=>
            uop_valid && uop_next_seq == SEQ_W'($past(uop_next_seq) + 1));  // R8

    AST_LAST_WRAP: assert property (@(posedge clk) disable iff (rst)
        uop_valid && uop_last |-> uop_next_seq == '0);  // R8

    AST_IMM_FINISH: assert property (@(posedge clk) disable iff (rst)
        uop_valid |-> uop_imm_a == IMM_W'(uop_last));  // R9

    AST_FINISH_IDLE: assert property (@(posedge clk) disable iff (rst)
        uop_valid && uop_ready && uop_last |=> start_ready && !uop_valid);  // R10

endmodule

bind mma_uop_seq mma_uop_seq_chk #(
    .REG_W   (REG_W),
    .IMM_W   (IMM_W),
    .SEQ_W   (SEQ_W),
    .RS2_GAP (NUM_SETS * NUM_SUBSTEPS)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_valid  (start_valid),
    .start_ready  (start_ready),
    .uop_valid    (uop_valid),
    .uop_ready    (uop_ready),
    .uop_imm_a    (uop_imm_a),
    .uop_rs1      (uop_rs1),
    .uop_rs2      (uop_rs2),
    .uop_rd       (uop_rd),
    .uop_last     (uop_last),
    .uop_next_seq (uop_next_seq)
);

// File: tb/tb_mma_uop_seq.sv
`timescale 1ns/1ps
module tb_mma_uop_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_valid = 1'b0;
    logic        uop_ready = 1'b0;
    logic        start_ready, uop_valid, uop_last;
    logic [2:0]  uop_exec_unit, uop_flags, uop_modifier;
    logic [3:0]  uop_opcode;
    logic [31:0] uop_imm_a, uop_imm_b;
    logic [4:0]  uop_rs1, uop_rs2, uop_rs3, uop_rd, uop_next_seq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference model state
    bit m_busy = 0;
    int m_seq = 0;
    bit m_just_done = 0;

    always #2 clk = ~clk;  // 250 MHz

    mma_uop_seq dut (
        .clk(clk), .rst(rst),
        .start_valid(start_valid), .start_ready(start_ready),
        .uop_valid(uop_valid), .uop_ready(uop_ready),
        .uop_exec_unit(uop_exec_unit), .uop_opcode(uop_opcode),
        .uop_modifier(uop_modifier), .uop_flags(uop_flags),
        .uop_imm_a(uop_imm_a), .uop_imm_b(uop_imm_b),
        .uop_rs1(uop_rs1), .uop_rs2(uop_rs2), .uop_rs3(uop_rs3),
        .uop_rd(uop_rd), .uop_last(uop_last), .uop_next_seq(uop_next_seq)
    );

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (seq %0d, t=%0t)",
                     req, what, act, exp, m_seq, $time);
        end
    endtask

    task automatic compare();
        int set_n, step_n, sub_n, lst;
        check(m_just_done ? "R10" : "R2", "start_ready", start_ready, !m_busy);
        check(m_just_done ? "R10" : "R3", "uop_valid", uop_valid, m_busy);
        if (m_busy) begin
            set_n  = m_seq / 8;
            step_n = (m_seq % 8) / 2;
            sub_n  = m_seq % 2;
            lst    = (m_seq == 31) ? 1 : 0;
            check("R4", "opcode", uop_opcode, step_n);
            check("R4", "modifier", uop_modifier, sub_n);
            check("R5", "rs1", uop_rs1, 2 * set_n + sub_n);
            check("R6", "rs2", uop_rs2, 8 + 2 * set_n + sub_n);
            check("R7", "rs3", uop_rs3, 16 + 2 * step_n + sub_n);
            check("R7", "rd", uop_rd, 16 + 2 * step_n + sub_n);
            check("R8", "last", uop_last, lst);
            check("R8", "next_seq", uop_next_seq, (m_seq + 1) % 32);
            check("R9", "imm_a", uop_imm_a, lst);
            check("R9", "imm_b", uop_imm_b, lst);
            check("R9", "flags", uop_flags, 4);
            check("R9", "exec_unit", uop_exec_unit, 4);
        end
    endtask

    // one cycle: compare at negedge, drive, update model after posedge
    task automatic cycle(int p_start, int p_ready, bit do_rst);
        bit sv, rd;
        @(negedge clk);
        if (!rst) compare();
        sv = ($urandom_range(99, 0) < p_start);
        rd = ($urandom_range(99, 0) < p_ready);
        start_valid = sv;
        uop_ready   = rd;
        rst         = do_rst;
        @(posedge clk);
        m_just_done = 0;
        if (do_rst) begin
            m_busy = 0;
            m_seq  = 0;
        end else if (!m_busy) begin
            if (sv) m_busy = 1;
        end else if (rd) begin
            if (m_seq == 31) begin
                m_busy = 0;
                m_seq = 0;
                m_just_done = 1;
            end else begin
                m_seq++;
            end
        end
    endtask

    task automatic run(int n, int p_start, int p_ready);
        for (int i = 0; i < n; i++) cycle(p_start, p_ready, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) cycle(0, 0, 1'b1);
        @(negedge clk);
        check("R1", "start_ready after reset", start_ready, 1);
        check("R1", "uop_valid after reset", uop_valid, 0);
        run(5, 0, 100);          // idle, ready high: nothing issued (R1)
        run(200, 100, 100);      // full throughput runs
        run(1500, 30, 50);       // random handshakes
        run(600, 100, 15);       // heavy stall, start always high (R2, R10)
        run(20, 100, 100);
        cycle(100, 100, 1'b1);   // reset mid-run (R1)
        run(300, 100, 100);      // back-to-back restarts at 0 (R10)
        run(400, 60, 80);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule